// File: doc/BRIEF.md
# Dual-Speed Ethernet Transmit Output Stage

This block is the last stage of an Ethernet MAC transmit path before the pins. It serves a PHY that can run either the 10/100 byte-nibble interface (MII) or the gigabit interface (GMII). The upper bit of a two-bit speed code from the management logic chooses the transmit clock. When that bit is 1 the clock is a local 125 MHz reference, and when it is 0 the clock is the one the PHY drives at 10/100. The chosen clock is exported, and the rest of the MAC transmit logic runs on it.

The source switch is a plain asynchronous multiplexer, because the PHY clock may stop once the link moves to gigabit. Any change of the speed code therefore starts a full core reset. That reset lasts a fixed number of cycles of the newly selected clock. The gigabit clock sent to the PHY comes from a double-data-rate output register with its phases swapped, so the forwarded clock is the inverse of the internal clock. Data and enable bits then change on the falling edge of the forwarded clock, which centres them on its rising edge.

Top module: `tx_out_stage`

## Requirements
- R1: When `speed_code[1]` is 1 the exported clock `tx_clk_out` follows `clk_ref`; when it is 0 it follows `clk_phy`.
- R2: Outside reset, `pad_txd` and `pad_txen` equal the `mac_txd` and `mac_txen` values that were present at the previous rising edge of `tx_clk_out`. This is one registered stage.
- R3: `speed_code` passes through two synchronising flops in the `tx_clk_out` domain. A change in the synchronised code raises `core_rst` after the next rising edge, which is the third rising edge after the input changed.
- R4: `core_rst` stays high for exactly `RST_CYCLES` (default 16) rising edges after the last detected change. A further change during reset restarts that count.
- R5: At every rising edge where `core_rst` is high, `pad_txd` is loaded with 0 and `pad_txen` with 0.
- R6: When the synchronised upper speed bit is 1, `pad_gtx_clk` goes low at every rising edge of `tx_clk_out` and high at every falling edge. It is the inverted internal clock.
- R7: When the synchronised upper speed bit is 0, `pad_gtx_clk` is held low and does not toggle.
- R8: While `arst_n` is low, `core_rst` is high and `pad_gtx_clk` is low. After release, `core_rst` stays high for at least `RST_CYCLES` edges.
- R9: A change in the lower speed bit alone (10 versus 100 Mb/s, same clock source) also triggers the reset of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Local gigabit reference clock |
| clk_phy | input | 1 | PHY-supplied transmit clock at 10/100 |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| speed_code | input | 2 | Link speed; bit 1 = gigabit, bit 0 = 100 Mb/s when bit 1 is 0 |
| mac_txd | input | DATA_W | Transmit data from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| tx_clk_out | output | 1 | Selected transmit clock for the MAC |
| core_rst | output | 1 | Reset request for the MAC core, active high |
| pad_gtx_clk | output | 1 | Forwarded gigabit clock to the PHY |
| pad_txd | output | DATA_W | Registered transmit data to the PHY |
| pad_txen | output | 1 | Registered transmit enable to the PHY |

## Verification
A stale synchroniser or a wrong change detector shows at the ports as a missing or late `core_rst`. That is visible three edges after the speed code moves. A reset counter off by one either releases the data pins one edge early or holds them at zero one edge too long. The gap between the forwarded-clock enable and the selected clock source shows up within one half period: `pad_gtx_clk` toggles in 10/100 mode, or has the wrong level just after a rising edge in gigabit mode. Data and enable are compared against a behavioural model at every edge, so a latency error is reported on the first non-reset cycle.

// File: rtl/tx_out_stage.sv
`timescale 1ns/1ps
module tx_out_stage #(
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk_ref,
  input  logic              clk_phy,
  input  logic              arst_n,
  input  logic [1:0]        speed_code,
  input  logic [DATA_W-1:0] mac_txd,
  input  logic              mac_txen,
  output logic              tx_clk_out,
  output logic              core_rst,
  output logic              pad_gtx_clk,
  output logic [DATA_W-1:0] pad_txd,
  output logic              pad_txen
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);
  localparam logic PHASE_HI = 1'b1;
  localparam logic PHASE_LO = 1'b0;

  logic             tx_clk;
  logic [1:0]       spd_s1, spd_s2, spd_seen;
  logic [CNT_W-1:0] rst_cnt;
  logic             rise_q, fall_q;
  logic             gtx_ce;

  assign tx_clk     = speed_code[1] ? clk_ref : clk_phy;
  assign tx_clk_out = tx_clk;

  always_ff @(posedge tx_clk or negedge arst_n) begin
    if (!arst_n) begin
      spd_s1   <= '0;
      spd_s2   <= '0;
      spd_seen <= '0;
      rst_cnt  <= CNT_LOAD;
    end else begin
      spd_s1   <= speed_code;
      spd_s2   <= spd_s1;
      spd_seen <= spd_s2;
      if (spd_s2 != spd_seen)
        rst_cnt <= CNT_LOAD;
      else if (rst_cnt != '0)
        rst_cnt <= rst_cnt - 1'b1;
    end
  end

  assign core_rst = (rst_cnt != '0);

  assign gtx_ce = spd_s2[1];

  always_ff @(posedge tx_clk or negedge arst_n) begin
    if (!arst_n)     rise_q <= 1'b0;
    else if (gtx_ce) rise_q <= fall_q ^ PHASE_LO;
  end

  always_ff @(negedge tx_clk or negedge arst_n) begin
    if (!arst_n)     fall_q <= 1'b0;
    else if (gtx_ce) fall_q <= rise_q ^ PHASE_HI;
  end

  assign pad_gtx_clk = rise_q ^ fall_q;

  always_ff @(posedge tx_clk) begin
    if (core_rst) begin
      pad_txd  <= '0;
      pad_txen <= 1'b0;
    end else begin
      pad_txd  <= mac_txd;
      pad_txen <= mac_txen;
    end
  end
endmodule

module tx_out_stage_chk #(
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input logic              tx_clk,
  input logic              arst_n,
  input logic              core_rst,
  input logic [1:0]        sync_code,
  input logic [DATA_W-1:0] mac_txd,
  input logic              mac_txen,
  input logic [DATA_W-1:0] pad_txd,
  input logic              pad_txen,
  input logic              pad_gtx_clk
);
  logic [1:0] armed_cnt;
  logic       armed;
  int         run_len;

  always_ff @(posedge tx_clk or negedge arst_n) begin
    if (!arst_n) begin
      armed_cnt <= '0;
      run_len   <= 0;
    end else begin
      if (armed_cnt != 2'd3) armed_cnt <= armed_cnt + 1'b1;
      run_len <= core_rst ? run_len + 1 : 0;
    end
  end

  assign armed = (armed_cnt == 2'd3);

  // R5
  rst_zero_chk: assert property (@(posedge tx_clk) disable iff (!arst_n)
    armed && core_rst |=> (pad_txd == '0) && !pad_txen);

  // R2
  latency_chk: assert property (@(posedge tx_clk) disable iff (!arst_n)
    armed && !core_rst |=> (pad_txd == $past(mac_txd)) && (pad_txen == $past(mac_txen)));

  // R3
  change_rst_chk: assert property (@(posedge tx_clk) disable iff (!arst_n)
    armed && (sync_code != $past(sync_code)) |=> core_rst);

  // R4
  rst_len_chk: assert property (@(posedge tx_clk) disable iff (!arst_n)
    $fell(core_rst) |-> run_len >= RST_CYCLES);

  // R6
  gtx_high_chk: assert property (@(posedge tx_clk) disable iff (!arst_n)
    armed && sync_code[1] && $past(sync_code[1]) |-> pad_gtx_clk);

  // R7
  gtx_quiet_chk: assert property (@(posedge tx_clk) disable iff (!arst_n)
    armed && !sync_code[1] && !$past(sync_code[1]) |-> !pad_gtx_clk);
endmodule

bind tx_out_stage tx_out_stage_chk #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .tx_clk(tx_clk_out),
  .arst_n(arst_n),
  .core_rst(core_rst),
  .sync_code(spd_s2),
  .mac_txd(mac_txd),
  .mac_txen(mac_txen),
  .pad_txd(pad_txd),
  .pad_txen(pad_txen),
  .pad_gtx_clk(pad_gtx_clk)
);

// File: tb/test_tx_out_stage.sv
`timescale 1ns/1ps
module test_tx_out_stage;
  localparam int DW = 8;
  localparam int RC = 16;

  logic          clk_ref = 1'b0, clk_phy = 1'b0, arst_n = 1'b0;
  logic [1:0]    speed_code = 2'b01;
  logic [DW-1:0] mac_txd = '0;
  logic          mac_txen = 1'b0;
  logic          tx_clk_out, core_rst, pad_gtx_clk, pad_txen;
  logic [DW-1:0] pad_txd;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] sync_q[$];
  logic [1:0] m_seen;
  int         m_cnt;
  logic       m_ce;
  logic [15:0] lfsr = 16'hACE1;

  tx_out_stage #(.DATA_W(DW), .RST_CYCLES(RC)) i_tx_out_stage (
    .clk_ref(clk_ref), .clk_phy(clk_phy), .arst_n(arst_n),
    .speed_code(speed_code), .mac_txd(mac_txd), .mac_txen(mac_txen),
    .tx_clk_out(tx_clk_out), .core_rst(core_rst), .pad_gtx_clk(pad_gtx_clk),
    .pad_txd(pad_txd), .pad_txen(pad_txen));

  always #2.5 clk_ref = ~clk_ref;
  always #20  clk_phy = ~clk_phy;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_init();
    sync_q = {2'b00, 2'b00};
    m_seen = 2'b00;
    m_cnt  = RC;
    m_ce   = 1'b0;
  endtask

  always @(posedge tx_clk_out) begin
    if (arst_n) begin
      logic [1:0]    s2_pre, code_now;
      logic          rst_pre, en_in;
      logic [DW-1:0] d_in;
      code_now = speed_code;
      d_in     = mac_txd;
      en_in    = mac_txen;
      rst_pre  = (m_cnt != 0);
      s2_pre   = sync_q[0];
      if (s2_pre != m_seen) m_cnt = RC;
      else if (m_cnt != 0)  m_cnt = m_cnt - 1;
      m_seen = s2_pre;
      void'(sync_q.pop_front());
      sync_q.push_back(code_now);
      m_ce = sync_q[0][1];
      #1;
      chk("R1 clock source", code_now[1] ? clk_ref : clk_phy, 1);
      chk("R2/R5 pad_txd", pad_txd, rst_pre ? '0 : d_in);
      chk("R2/R5 pad_txen", pad_txen, rst_pre ? 1'b0 : en_in);
      chk("R3/R4/R9 core_rst", core_rst, m_cnt != 0);
      chk("R6/R7 gtx low after rise", pad_gtx_clk, 0);
    end
  end

  always @(negedge tx_clk_out) begin
    if (arst_n) begin
      #1;
      chk(m_ce ? "R6 gtx high after fall" : "R7 gtx silent", pad_gtx_clk, m_ce);
    end
  end

  task automatic run(input int n);
    repeat (n) begin
      @(negedge tx_clk_out);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mac_txd  = lfsr[DW-1:0];
      mac_txen = lfsr[9];
    end
  endtask

  task automatic switch_source(input logic [1:0] code);
    @(negedge clk_phy);
    #0.5;
    speed_code = code;
  endtask

  initial begin
    model_init();
    #50;
    chk("R8 core_rst in reset", core_rst, 1);
    chk("R8 gtx low in reset", pad_gtx_clk, 0);
    #53;
    arst_n = 1'b1;
    #1;
    chk("R8 core_rst after release", core_rst, 1);
    run(40);
    @(negedge tx_clk_out);
    speed_code = 2'b00;
    run(30);
    switch_source(2'b10);
    run(60);
    @(negedge tx_clk_out);
    speed_code = 2'b11;
    run(10);
    @(negedge tx_clk_out);
    speed_code = 2'b10;
    run(60);
    switch_source(2'b01);
    run(40);
    @(negedge tx_clk_out);
    speed_code = 2'b00;
    run(8);
    @(negedge tx_clk_out);
    speed_code = 2'b01;
    run(40);
    #5;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule